// File: doc/BRIEF.md
# Branch Resolution Fetch Controller

This block steers instruction fetch in a five-stage integer pipeline (fetch, decode, execute, memory, write-back) that settles conditional branches while they are still in decode. A zero test on the first source operand and a dedicated target adder both sit in the decode stage. The target is the branch's incremented PC plus the sign-extended 16-bit offset. Because the outcome and the target are known one stage after fetch, a control hazard costs at most one fetch slot.

The controller drives the next PC, the PC write enable, the IF/ID write enable and a squash line. The squash line clears the valid bit that the IF/ID register loads, so the fetched instruction becomes a no-op. Downstream write enables are gated by that valid bit.

A static policy is captured while reset is held and applies until the next reset. Three policies are available:
- **Freeze:** every branch costs one bubble, whatever its outcome.
- **Predict not taken:** fetch runs on sequentially, and only a taken branch costs a bubble.
- **Delayed branch:** the instruction after the branch always executes, and a taken branch redirects fetch without any squash.

A branch found in a delay slot is outside the supported behaviour. In that case the block raises an error flag and does not act on that branch.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While rst_n is low, pc_we_o, ifid_we_o, squash_o and slot_err_o are 0. While rst_n is low, policy_i is captured with this encoding: 0 = freeze, 1 = predict not taken, 2 = delayed branch, 3 = freeze.
- R2: The branch kind br_kind_i is encoded as 0 = no branch, 1 = taken when rs_val_i is zero, 2 = taken when rs_val_i is nonzero, 3 = no branch. A branch is only acted on when id_valid_i is 1.
- R3: The redirect target is pc_inc_i plus imm_i sign-extended to 32 bits, computed modulo 2^32.
- R4: Out of reset, with no acted-on branch in decode, the outputs are next_pc_o = fetch_pc_inc_i, pc_we_o = 1, ifid_we_o = 1 and squash_o = 0. The same holds for a not-taken branch under predict not taken, so that case costs no stall.
- R5: Under predict not taken, a taken branch gives next_pc_o = target, pc_we_o = 1 and squash_o = 1.
- R6: Under freeze, every acted-on branch gives squash_o = 1. A taken branch also gives pc_we_o = 1 and next_pc_o = target. A not-taken branch gives pc_we_o = 0, so the PC is held.
- R7: Under delayed branch, a taken branch gives next_pc_o = target, pc_we_o = 1 and squash_o = 0. A not-taken branch behaves as in R4.
- R8: Under delayed branch, the cycle right after an acted-on branch is its slot. A valid branch seen in the slot sets slot_err_o = 1 and is not acted on, so the outputs follow R4. In every other case slot_err_o is 0, including under every other policy.
- R9: A change of policy_i after reset has no effect until the next reset.
- R10: ifid_we_o is 1 in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the policy is sampled while it is low |
| policy_i | input | 2 | Control-hazard policy select |
| id_valid_i | input | 1 | Valid bit of the instruction in decode |
| br_kind_i | input | 2 | Decoded branch kind |
| rs_val_i | input | 32 | First source operand value |
| imm_i | input | 16 | Signed branch offset |
| pc_inc_i | input | 32 | Incremented PC of the instruction in decode |
| fetch_pc_inc_i | input | 32 | Incremented PC of the instruction in fetch |
| next_pc_o | output | 32 | Value for the PC register |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | IF/ID write enable |
| squash_o | output | 1 | Clears the valid bit loaded into IF/ID |
| slot_err_o | output | 1 | A branch was found in a delay slot |

## Verification
Some properties are checked by assertions on every cycle:
- a redirect always writes the PC;
- delayed-branch mode never squashes;
- freeze always squashes an acted-on branch;
- a slot error never coincides with a redirect.

Other behaviour can only be shown by the bench's scenarios. This covers the exact target arithmetic for edge offsets, the zero test on extreme operand values, the carry of the delay-slot state from one cycle into the next, and the fact that the policy is frozen once reset is released.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQZ  = 2'd1,
    BK_NEZ  = 2'd2,
    BK_RSVD = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    POL_FREEZE = 2'd0,
    POL_PNT    = 2'd1,
    POL_DELAY  = 2'd2,
    POL_RSVD   = 2'd3
  } policy_e;

  // Sign-extend a 16-bit branch offset to 32 bits.
  function automatic logic [31:0] sext16(input logic [15:0] off);
    return {{16{off[15]}}, off};
  endfunction

  // R2: condition outcome for a branch kind and an operand value.
  function automatic logic cond_met(input br_kind_e k, input logic [31:0] v);
    logic z;
    z = (v == '0);
    case (k)
      BK_EQZ:  return z;
      BK_NEZ:  return !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_branch_kind(input br_kind_e k);
    return (k == BK_EQZ) || (k == BK_NEZ);
  endfunction

endpackage

// File: rtl/bfc_resolve.sv
module bfc_resolve
  import bfc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 16
) (
  input  logic [1:0]      kind_i,
  input  logic [DW-1:0]   rs_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [AW-1:0]   pc_inc_i,
  output logic            is_br_o,
  output logic            taken_o,
  output logic [AW-1:0]   target_o
);
  br_kind_e kind;
  logic [31:0] rs_ext;
  logic [31:0] off_ext;
  logic [31:0] tgt_full;

  always_comb begin
    kind     = br_kind_e'(kind_i);
    rs_ext   = 32'(rs_i);
    off_ext  = sext16(16'(off_i));
    tgt_full = 32'(pc_inc_i) + off_ext;
    is_br_o  = is_branch_kind(kind);
    taken_o  = cond_met(kind, rs_ext);
    target_o = AW'(tgt_full);
  end
endmodule

// File: rtl/bfc_mode_latch.sv
module bfc_mode_latch
  import bfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy_i,
  output logic       freeze_o,
  output logic       pnt_o,
  output logic       delay_o
);
  policy_e pol_q;

  // R1/R9: the policy is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= policy_e'(policy_i);
  end

  always_comb begin
    pnt_o    = (pol_q == POL_PNT);
    delay_o  = (pol_q == POL_DELAY);
    freeze_o = !(pnt_o || delay_o);
  end
endmodule

// File: rtl/bfc_steer.sv
module bfc_steer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_i,
  input  logic          pnt_i,
  input  logic          delay_i,
  input  logic          id_valid_i,
  input  logic          is_br_i,
  input  logic          taken_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] seq_pc_i,
  output logic [AW-1:0] next_pc_o,
  output logic          pc_we_o,
  output logic          ifid_we_o,
  output logic          squash_o,
  output logic          slot_err_o
);
  logic slot_q;
  logic br_seen;
  logic br_act;
  logic redirect;
  logic hold_pc;

  always_comb begin
    br_seen  = id_valid_i && is_br_i;
    br_act   = br_seen && !slot_q;
    redirect = br_act && taken_i;
    hold_pc  = freeze_i && br_act && !taken_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= 1'b0;
    else        slot_q <= delay_i && br_act;
  end

  always_comb begin
    next_pc_o  = redirect ? target_i : seq_pc_i;
    pc_we_o    = rst_n && !hold_pc;
    ifid_we_o  = rst_n;
    squash_o   = rst_n && br_act && (freeze_i || (pnt_i && taken_i));
    slot_err_o = rst_n && slot_q && br_seen;
  end

  // R5 R6 R7
  redirect_writes_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> pc_we_o);

  // R7
  delay_never_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_i |-> !squash_o);

  // R6
  freeze_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && br_seen) |-> squash_o);

  // R8
  slot_err_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err_o |-> (next_pc_o == seq_pc_i && !squash_o && $past(delay_i)));

  // R8
  slot_err_only_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !delay_i |-> !slot_err_o);

  // R10
  ifid_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_we_o);
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      policy_i,
  input  logic            id_valid_i,
  input  logic [1:0]      br_kind_i,
  input  logic [DW-1:0]   rs_val_i,
  input  logic [OFFW-1:0] imm_i,
  input  logic [AW-1:0]   pc_inc_i,
  input  logic [AW-1:0]   fetch_pc_inc_i,
  output logic [AW-1:0]   next_pc_o,
  output logic            pc_we_o,
  output logic            ifid_we_o,
  output logic            squash_o,
  output logic            slot_err_o
);
  logic          m_freeze;
  logic          m_pnt;
  logic          m_delay;
  logic          is_br;
  logic          taken;
  logic [AW-1:0] target;

  bfc_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .policy_i (policy_i),
    .freeze_o (m_freeze),
    .pnt_o    (m_pnt),
    .delay_o  (m_delay)
  );

  bfc_resolve #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_resolve (
    .kind_i   (br_kind_i),
    .rs_i     (rs_val_i),
    .off_i    (imm_i),
    .pc_inc_i (pc_inc_i),
    .is_br_o  (is_br),
    .taken_o  (taken),
    .target_o (target)
  );

  bfc_steer #(.AW(AW)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_i   (m_freeze),
    .pnt_i      (m_pnt),
    .delay_i    (m_delay),
    .id_valid_i (id_valid_i),
    .is_br_i    (is_br),
    .taken_i    (taken),
    .target_i   (target),
    .seq_pc_i   (fetch_pc_inc_i),
    .next_pc_o  (next_pc_o),
    .pc_we_o    (pc_we_o),
    .ifid_we_o  (ifid_we_o),
    .squash_o   (squash_o),
    .slot_err_o (slot_err_o)
  );

  // R1: one-hot mode decode is always consistent
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m_freeze, m_pnt, m_delay}) == 1);
endmodule

// File: tb/test_branch_fetch_ctrl.sv
module test_branch_fetch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = 2'd0;
  logic        idv = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [31:0] rs = '0;
  logic [15:0] imm = '0;
  logic [31:0] pci = '0;
  logic [31:0] fpci = '0;
  logic [31:0] npc;
  logic        pcwe, ifwe, sq, serr;

  int total = 0;
  int bad = 0;
  bit m_slot = 1'b0;
  int pol_eff = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  branch_fetch_ctrl i_branch_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .id_valid_i(idv),
    .br_kind_i(kind), .rs_val_i(rs), .imm_i(imm), .pc_inc_i(pci),
    .fetch_pc_inc_i(fpci), .next_pc_o(npc), .pc_we_o(pcwe),
    .ifid_we_o(ifwe), .squash_o(sq), .slot_err_o(serr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic do_reset(input logic [1:0] p);
    @(posedge clk); #1;
    rst_n = 1'b0; policy = p;
    idv = 1'b1; kind = 2'd1; rs = '0; imm = 16'h0010;
    pci = 32'h100; fpci = 32'h104;
    @(posedge clk); #1;
    @(posedge clk); #4;
    // R1: outputs quiet in reset even with a taken branch presented
    chk("R1", "pc_we in reset", 32'(pcwe), 0);
    chk("R1", "ifid_we in reset", 32'(ifwe), 0);
    chk("R1", "squash in reset", 32'(sq), 0);
    chk("R1", "slot_err in reset", 32'(serr), 0);
    @(posedge clk); #1;
    rst_n = 1'b1; idv = 1'b0; kind = 2'd0;
    m_slot = 1'b0;
    pol_eff = (p == 2'd3) ? 0 : int'(p);
  endtask

  // Present one vector, check combinational outputs mid-cycle, advance the model.
  task automatic vec(input logic v, input logic [1:0] k, input logic [31:0] r,
                     input logic [15:0] o, input logic [31:0] pi, input logic [31:0] fi,
                     input string tag);
    bit br_raw, br, tk, redir, exp_sq, exp_we, exp_err;
    logic [31:0] tgt, exp_pc;
    @(posedge clk); #1;
    idv = v; kind = k; rs = r; imm = o; pci = pi; fpci = fi;
    #4;
    br_raw = v && (k == 2'd1 || k == 2'd2);
    br = br_raw && !m_slot;
    tk = (k == 2'd1) ? (r == 0) : (r != 0);
    tgt = pi + 32'($signed(o));          // R3
    redir = br && tk;
    exp_err = m_slot && br_raw;          // R8
    case (pol_eff)
      0: begin exp_sq = br; exp_we = !(br && !tk); end          // R6
      1: begin exp_sq = redir; exp_we = 1'b1; end               // R4 R5
      default: begin exp_sq = 1'b0; exp_we = 1'b1; end          // R7
    endcase
    exp_pc = redir ? tgt : fi;
    chk(tag, "next_pc", npc, exp_pc);
    chk(tag, "pc_we", 32'(pcwe), 32'(exp_we));
    chk("R10", "ifid_we", 32'(ifwe), 1);
    chk(tag, "squash", 32'(sq), 32'(exp_sq));
    chk("R8", "slot_err", 32'(serr), 32'(exp_err));
    m_slot = (pol_eff == 2) && br;
  endtask

  function automatic string tag_for(input int p);
    case (p)
      0: return "R6";
      1: return "R5";
      default: return "R7";
    endcase
  endfunction

  initial begin
    logic [31:0] rsv [4];
    logic [15:0] offv [5];
    rsv[0] = 32'h0; rsv[1] = 32'h1; rsv[2] = 32'hFFFF_FFFF; rsv[3] = 32'h8000_0000;
    offv[0] = 16'h0; offv[1] = 16'h0004; offv[2] = 16'hFFFC; offv[3] = 16'h7FFF; offv[4] = 16'h8000;

    for (int p = 0; p < 4; p++) begin
      do_reset(2'(p));
      for (int k = 0; k < 4; k++)
        for (int ri = 0; ri < 4; ri++)
          for (int oi = 0; oi < 5; oi++)
            for (int v = 0; v < 2; v++) begin
              logic [31:0] base;
              lcg = nxt(lcg);
              base = {lcg[31:2], 2'b00};
              // R2 R3 R4 and the per-policy requirement
              vec(v[0], 2'(k), rsv[ri], offv[oi], base + 32'd4, base + 32'd8,
                  tag_for((p == 3) ? 0 : p));
            end
      // R8: explicit branch directly in a delay slot (errors only under delay)
      vec(1'b1, 2'd2, 32'd5, 16'h0020, 32'h0000_2004, 32'h0000_2008, "R8");
      vec(1'b1, 2'd1, 32'd0, 16'h0040, 32'h0000_2008, 32'h0000_200C, "R8");
      vec(1'b1, 2'd1, 32'd0, 16'h0040, 32'h0000_3008, 32'h0000_300C, "R8");
      // R3: target wraps modulo 2^32
      vec(1'b1, 2'd1, 32'd0, 16'h0010, 32'hFFFF_FFF8, 32'hFFFF_FFFC, "R3");
      vec(1'b0, 2'd0, 32'd0, 16'h0, 32'h10, 32'h14, "R4");
    end

    // R9: policy change after reset is ignored
    do_reset(2'd1);
    @(posedge clk); #1; policy = 2'd2;
    vec(1'b1, 2'd2, 32'd7, 16'h0008, 32'h0000_0400, 32'h0000_0404, "R9");
    vec(1'b0, 2'd0, 32'd0, 16'h0, 32'h0000_0408, 32'h0000_040C, "R9");
    @(posedge clk); #1; policy = 2'd1;
    vec(1'b1, 2'd1, 32'd3, 16'h0008, 32'h0000_0500, 32'h0000_0504, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule